// File: doc/BRIEF.md
# Ordered Power-Rail Enable Sequencer

This block brings up five power-rail enables in a fixed group order after a single start pulse. The top rail always comes first. It is followed by a pair of rails whose relative order is picked pseudo-randomly. A last pair follows, ordered the same way. Between consecutive rail steps the block waits a pseudo-random number of clock cycles taken from a bounded window. A 16-bit linear feedback shift register supplies both the gap lengths and the pair-order choices. It is loaded from a seed input when start is accepted, so a given seed always reproduces the same bring-up.

A power-management controller or a stimulus environment uses the block to exercise many legal bring-up orderings and timings from a single seed. Enables are levels: once raised, a rail stays on until reset. A completion flag reports that every rail is on. The block runs one sequence per reset.

Top module: `rail_seq`

## Requirements
- R1: A synchronous active-high reset clears all five enables and the done flag, and leaves the block idle waiting for start.
- R2: The top-rail enable (`en_top`) is the first enable to rise, on its own step.
- R3: Neither second-pair enable (`en_p2a`, `en_p2b`) rises before `en_top` is high. Neither third-pair enable (`en_p3a`, `en_p3b`) rises before both second-pair enables are high.
- R4: Let L be the register value used for a step. On step 1, bit 0 of L equal to 0 raises `en_p2a` and 1 raises `en_p2b`, and step 2 raises the other one. On step 3, bit 0 of L equal to 0 raises `en_p3a` and 1 raises `en_p3b`, and step 4 raises the other one.
- R5: On accepting start, the register is loaded with `seed`, or with 1 when `seed` is 0. Step k (k = 0..4) uses state L_k and waits GAP_MIN + (L_k mod (GAP_MAX-GAP_MIN+1)) cycles, counted from the start edge for k = 0 and from the previous rise otherwise. L_{k+1} is L_k shifted left by one with the XOR of bits 15, 13, 12 and 10 entering bit 0. With the defaults of 20 and 30, every gap lies between 20 and 30 cycles inclusive.
- R6: Once an enable is high it stays high until reset.
- R7: At most one enable rises in any cycle, and exactly five steps occur per sequence.
- R8: `done` rises one cycle after the fifth enable rises and stays high until reset.
- R9: A start pulse while a sequence is running, or after it has completed, is ignored: enable timings and order are unchanged and no enable drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a sequence when idle |
| seed | input | 16 | Initial value for the pseudo-random register |
| en_top | output | 1 | Top rail enable |
| en_p2a | output | 1 | Second-pair rail A enable |
| en_p2b | output | 1 | Second-pair rail B enable |
| en_p3a | output | 1 | Third-pair rail A enable |
| en_p3b | output | 1 | Third-pair rail B enable |
| done | output | 1 | All rails on |

## Verification
Both pair orderings must be reached, along with gaps at the ends of the 20 to 30 window. Both depend on the register state several steps into a run, so no single input pattern produces them. The bench sweeps a wide set of seeds, including zero and all-ones, and predicts every rise cycle arithmetically from R5. The other hard case is a second start that arrives in the middle of a running sequence. Some runs inject one with a different seed partway through the first gap, and the bench confirms that the predicted timeline does not shift.

// File: rtl/rail_seq.sv
module rail_seq #(
  parameter int GAP_MIN = 20,
  parameter int GAP_MAX = 30,
  parameter int LW      = 16,
  parameter logic [LW-1:0] TAPS = 16'hB400
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [LW-1:0] seed,
  output logic          en_top,
  output logic          en_p2a,
  output logic          en_p2b,
  output logic          en_p3a,
  output logic          en_p3b,
  output logic          done
);
  localparam int SPAN = GAP_MAX - GAP_MIN + 1;
  localparam int CW   = $clog2(GAP_MAX + 1);

  logic [LW-1:0] lfsr, lfsr_nxt, seed_nz;
  logic [CW-1:0] cnt;
  logic [2:0]    step;
  logic          run, ord, fire, go;
  logic [4:0]    en, pick;

  function automatic logic [CW-1:0] gap_of(input logic [LW-1:0] v);
    logic [31:0] m;
    m = 32'(v) % 32'(SPAN);
    return CW'(32'(GAP_MIN) - 32'd1 + m);
  endfunction

  assign seed_nz  = (seed == '0) ? LW'(1) : seed;
  assign lfsr_nxt = {lfsr[LW-2:0], ^(lfsr & TAPS)};
  assign fire     = run && (cnt == '0);
  assign go       = start && !run && (step == 3'd0);

  always_comb begin
    case (step)
      3'd0:    pick = 5'b00001;
      3'd1:    pick = lfsr[0] ? 5'b00100 : 5'b00010;
      3'd2:    pick = ord     ? 5'b00010 : 5'b00100;
      3'd3:    pick = lfsr[0] ? 5'b10000 : 5'b01000;
      3'd4:    pick = ord     ? 5'b01000 : 5'b10000;
      default: pick = 5'b00000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= '0;
      done <= 1'b0;
      run  <= 1'b0;
      ord  <= 1'b0;
      step <= '0;
      cnt  <= '0;
      lfsr <= LW'(1);
    end else begin
      done <= done | (&en);
      if (go) begin
        run  <= 1'b1;
        lfsr <= seed_nz;
        cnt  <= gap_of(seed_nz);
      end else if (fire) begin
        en   <= en | pick;
        lfsr <= lfsr_nxt;
        cnt  <= gap_of(lfsr_nxt);
        step <= step + 3'd1;
        if (step == 3'd1 || step == 3'd3) ord <= lfsr[0];
        if (step == 3'd4) run <= 1'b0;
      end else if (run) begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  assign en_top = en[0];
  assign en_p2a = en[1];
  assign en_p2b = en[2];
  assign en_p3a = en[3];
  assign en_p3b = en[4];
endmodule

// File: rtl/rail_seq_chk.sv
module rail_seq_chk #(
  parameter int GAP_MIN = 20,
  parameter int GAP_MAX = 30
) (
  input logic clk,
  input logic rst,
  input logic en_top,
  input logic en_p2a,
  input logic en_p2b,
  input logic en_p3a,
  input logic en_p3b,
  input logic done
);
  logic [4:0] v, v_q;
  logic [7:0] since;
  logic       rise;

  assign v    = {en_p3b, en_p3a, en_p2b, en_p2a, en_top};
  assign rise = |(v & ~v_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q   <= '0;
      since <= '0;
    end else begin
      v_q <= v;
      if (rise) since <= 8'd1;
      else if (since != 8'hFF) since <= since + 8'd1;
    end
  end

  a_r2_top_first: assert property (@(posedge clk) disable iff (rst)
    (en_p2a | en_p2b | en_p3a | en_p3b) |-> en_top);
  a_r3_pair_order: assert property (@(posedge clk) disable iff (rst)
    (en_p3a | en_p3b) |-> (en_p2a & en_p2b));
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (v_q & ~v) == 5'b0);
  a_r7_one_rise: assert property (@(posedge clk) disable iff (rst)
    $countones(v & ~v_q) <= 1);
  a_r5_gap_window: assert property (@(posedge clk) disable iff (rst)
    (rise && v_q != 5'b0) |-> (since >= 8'(GAP_MIN) && since <= 8'(GAP_MAX)));
  a_r8_done_all: assert property (@(posedge clk) disable iff (rst)
    done |-> (&v));
  a_r8_done_timing: assert property (@(posedge clk) disable iff (rst)
    ((&v) && !(&v_q)) |=> done);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (v == 5'b0 && !done));
endmodule

bind rail_seq rail_seq_chk #(.GAP_MIN(GAP_MIN), .GAP_MAX(GAP_MAX)) u_chk (
  .clk(clk), .rst(rst), .en_top(en_top), .en_p2a(en_p2a), .en_p2b(en_p2b),
  .en_p3a(en_p3a), .en_p3b(en_p3b), .done(done));

// File: tb/test_rail_seq.sv
module test_rail_seq;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [15:0] seed = '0;
  logic en_top, en_p2a, en_p2b, en_p3a, en_p3b, done;
  int checks = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  rail_seq i_rail_seq (.clk(clk), .rst(rst), .start(start), .seed(seed),
    .en_top(en_top), .en_p2a(en_p2a), .en_p2b(en_p2b), .en_p3a(en_p3a),
    .en_p3b(en_p3b), .done(done));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: cycles %0d expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [15:0] nxt(input logic [15:0] l);
    return {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
  endfunction

  function automatic logic [4:0] ens();
    return {en_p3b, en_p3a, en_p2b, en_p2a, en_top};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; start = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    chk(ens() == 5'b0, "R1 enables", int'(ens()), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
  endtask

  task automatic run_seq(input logic [15:0] s, input bit mid);
    int exp_t[5];
    int got_t[5];
    int exp_done, got_done, t;
    logic [15:0] l;
    logic o;
    int ord_ids[5];
    do_reset();
    l = (s == 16'd0) ? 16'd1 : s;
    t = 0;
    for (int k = 0; k < 5; k++) begin
      t += 20 + int'(l % 16'd11);
      if (k == 1) o = l[0];
      if (k == 3) o = l[0];
      case (k)
        0: ord_ids[k] = 0;
        1: ord_ids[k] = o ? 2 : 1;
        2: ord_ids[k] = o ? 1 : 2;
        3: ord_ids[k] = o ? 4 : 3;
        default: ord_ids[k] = o ? 3 : 4;
      endcase
      exp_t[ord_ids[k]] = t;
      l = nxt(l);
    end
    exp_done = t + 1;
    for (int i = 0; i < 5; i++) got_t[i] = -1;
    got_done = -1;
    seed = s; start = 1'b1;
    for (int e = 0; e < 165; e++) begin
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      if (mid && e == 9) begin start = 1'b1; seed = ~s; end
      for (int i = 0; i < 5; i++) begin
        if (ens()[i] && got_t[i] < 0) got_t[i] = e;
        if (!ens()[i] && got_t[i] >= 0) chk(0, "R6 enable dropped", i, 1);
      end
      if (done && got_done < 0) got_done = e;
      if (!done && got_done >= 0) chk(0, "R8 done dropped", 0, 1);
    end
    chk(got_t[0] == exp_t[0], mid ? "R9 top timing" : "R2 R5 top timing", got_t[0], exp_t[0]);
    chk(got_t[1] == exp_t[1], "R3 R4 R5 pair2 A timing", got_t[1], exp_t[1]);
    chk(got_t[2] == exp_t[2], "R3 R4 R5 pair2 B timing", got_t[2], exp_t[2]);
    chk(got_t[3] == exp_t[3], "R3 R4 R5 pair3 A timing", got_t[3], exp_t[3]);
    chk(got_t[4] == exp_t[4], "R3 R4 R5 R7 pair3 B timing", got_t[4], exp_t[4]);
    chk(got_done == exp_done, "R8 done timing", got_done, exp_done);
  endtask

  initial begin
    logic [15:0] s;
    run_seq(16'h0000, 1'b0);
    run_seq(16'hFFFF, 1'b0);
    run_seq(16'h8000, 1'b0);
    run_seq(16'h0001, 1'b1);
    for (int i = 0; i < 36; i++) begin
      s = 16'(i * 16'h1357 + 16'h00A5);
      run_seq(s, i[0]);
    end
    // R9: start after completion has no effect
    @(negedge clk); seed = 16'h1234; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int e = 0; e < 40; e++) begin
      @(negedge clk);
      if (ens() != 5'b11111 || !done) chk(0, "R9 start after done", int'(ens()), 31);
    end
    chk(ens() == 5'b11111 && done, "R9 state after late start", int'(ens()), 31);
    // R1: reset in the middle of a sequence
    do_reset();
    seed = 16'h0042; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int e = 0; e < 50; e++) @(negedge clk);
    chk(en_top == 1'b1, "R2 top on before mid reset", int'(en_top), 1);
    do_reset();
    for (int e = 0; e < 40; e++) @(negedge clk);
    chk(ens() == 5'b0 && !done, "R1 idle after mid reset", int'(ens()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule